// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block sits on the device side of a byte-wide host command link and gives that link access to a small internal register file. Each incoming byte is a command. Its upper nibble selects the operation and its lower nibble carries a 4-bit payload. The host builds an 8-bit register address one nibble at a time, and it builds a data byte the same way. A write is committed when the host sends the high data nibble. A read command returns exactly one reply byte.

The register file holds three registers. A read-only identity register returns a fixed code, so the host can confirm that the right logic is loaded. A scratch register lets the host test the link by writing a pattern and reading it back. A mode register selects the operating mode; the value 0x80 selects logic-analyzer capture. The scratch and mode registers also drive output ports.

Top module: `nibreg_decoder`

## Requirements
- R1: When `cmd_valid` is high, opcode 0x0 (bits [7:4]) loads address bits [3:0] from bits [3:0] of the command, and opcode 0x1 loads address bits [7:4] from bits [3:0]. In both cases the other address nibble keeps its value.
- R2: Opcode 0x2 latches the low data nibble. Opcode 0x3 writes the byte {command bits [3:0], latched low nibble} to the addressed register at that clock edge.
- R3: Opcode 0x4 raises `reply_valid` for exactly one cycle, in the cycle after the edge that accepts the command. `reply_data` holds the value of the addressed register. `reply_valid` is low at all other times.
- R4: Address 0x00 always reads 0xA6, and writes to it have no effect.
- R5: Address 0x0F is the scratch register. Writing 0x55 or 0xAA and reading it back returns the same value, and `scratch_reg` shows the stored value.
- R6: Address 0x03 is the mode register. It reads back the last value written, and `mode_reg` shows it (0x80 selects logic-analyzer mode).
- R7: Any other address reads 0x00, and writes to such an address change neither the scratch register nor the mode register.
- R8: Opcodes 0x5 to 0xF produce no reply, no write, and no change to the address or the data nibble.
- R9: The address and the low data nibble persist between commands. A second opcode 0x3 reuses the previously latched low nibble.
- R10: A synchronous active-high `rst` clears the address, the data nibble, the scratch register and the mode register, and it deasserts `reply_valid`.
- R11: Bytes presented while `cmd_valid` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command: opcode [7:4], payload [3:0] |
| reply_valid | output | 1 | Reply byte strobe |
| reply_data | output | 8 | Reply byte |
| mode_reg | output | 8 | Mode register contents |
| scratch_reg | output | 8 | Scratch register contents |

## Verification
A write and a read of the same register can land in consecutive cycles. The read then samples the register file in the cycle right after the write edge, so the commit and the read-mux path meet at one boundary. The stimulus table sends a high-nibble write followed immediately by a read, with no idle gap, for the scratch and mode registers. Each reply must already carry the new value, while the output port updates at that same edge. A read that directly follows an address-nibble change is also sent back to back, and it must use the new address.

// File: rtl/nibreg_pkg.sv
package nibreg_pkg;

    typedef enum logic [3:0] {
        OP_ADDR_LO    = 4'h0,
        OP_ADDR_HI    = 4'h1,
        OP_DATA_LO    = 4'h2,
        OP_DATA_HI_WR = 4'h3,
        OP_READ       = 4'h4
    } op_e;

    typedef struct packed {
        logic       ld_addr_lo;
        logic       ld_addr_hi;
        logic       ld_data_lo;
        logic       wr;
        logic       rd;
        logic [3:0] nib;
    } cmd_t;

    localparam logic [7:0] ID_CODE      = 8'hA6;
    localparam logic [7:0] ADDR_ID      = 8'h00;
    localparam logic [7:0] ADDR_MODE    = 8'h03;
    localparam logic [7:0] ADDR_SCRATCH = 8'h0F;

    function automatic cmd_t decode_cmd(input logic v, input logic [7:0] b);
        cmd_t c;
        c            = '0;
        c.nib        = b[3:0];
        if (v) begin
            c.ld_addr_lo = (b[7:4] == OP_ADDR_LO);
            c.ld_addr_hi = (b[7:4] == OP_ADDR_HI);
            c.ld_data_lo = (b[7:4] == OP_DATA_LO);
            c.wr         = (b[7:4] == OP_DATA_HI_WR);
            c.rd         = (b[7:4] == OP_READ);
        end
        return c;
    endfunction

endpackage

// File: rtl/nibreg_decode.sv
module nibreg_decode
    import nibreg_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output cmd_t       cmd
);
    always_comb cmd = decode_cmd(cmd_valid, cmd_byte);

    // R8
    unknown_op_quiet_chk: assert final (!(cmd_valid && cmd_byte[7:4] > 4'h4)
        || (cmd.wr == 1'b0 && cmd.rd == 1'b0 && cmd.ld_addr_lo == 1'b0
            && cmd.ld_addr_hi == 1'b0 && cmd.ld_data_lo == 1'b0));
endmodule

// File: rtl/nibreg_ptr.sv
module nibreg_ptr
    import nibreg_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int NIBS  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cmd_t                  cmd,
    output logic [NIB_W*NIBS-1:0] addr,
    output logic                  wr_en,
    output logic [2*NIB_W-1:0]    wr_data,
    output logic                  rd_en
);
    logic [NIB_W-1:0] data_lo;
    logic [NIBS-1:0]  ld;

    assign ld[0] = cmd.ld_addr_lo;
    assign ld[1] = cmd.ld_addr_hi;

    for (genvar g = 0; g < NIBS; g++) begin : g_addr_nib
        always_ff @(posedge clk) begin
            if (rst)        addr[g*NIB_W +: NIB_W] <= '0;
            else if (ld[g]) addr[g*NIB_W +: NIB_W] <= cmd.nib[NIB_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 data_lo <= '0;
        else if (cmd.ld_data_lo) data_lo <= cmd.nib[NIB_W-1:0];
    end

    assign wr_en   = cmd.wr;
    assign wr_data = {cmd.nib[NIB_W-1:0], data_lo};
    assign rd_en   = cmd.rd;

    // R1
    addr_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.ld_addr_lo |=> addr[NIB_W-1:0] == $past(cmd.nib[NIB_W-1:0]));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd.ld_addr_lo && !cmd.ld_addr_hi |=> $stable(addr));
endmodule

// File: rtl/nibreg_bank.sv
module nibreg_bank
    import nibreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              reply_valid,
    output logic [DATA_W-1:0] reply_data,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] scratch_q
);
    logic [DATA_W-1:0] rd_mux;
    logic              hit_mode, hit_scratch, hit_id;

    assign hit_id      = (addr == ADDR_W'(ADDR_ID));
    assign hit_mode    = (addr == ADDR_W'(ADDR_MODE));
    assign hit_scratch = (addr == ADDR_W'(ADDR_SCRATCH));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            scratch_q <= '0;
        end else if (wr_en) begin
            if (hit_mode)    mode_q    <= wr_data;
            if (hit_scratch) scratch_q <= wr_data;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_id)      rd_mux = DATA_W'(ID_CODE);
        if (hit_mode)    rd_mux = mode_q;
        if (hit_scratch) rd_mux = scratch_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reply_valid <= 1'b0;
            reply_data  <= '0;
        end else begin
            reply_valid <= rd_en;
            if (rd_en) reply_data <= rd_mux;
        end
    end

    // R3
    reply_source_chk: assert property (@(posedge clk) disable iff (rst)
        reply_valid |-> $past(rd_en));

    // R4
    id_value_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && hit_id |=> reply_data == DATA_W'(ID_CODE));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hit_mode) |=> $stable(mode_q));

    // R5
    scratch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && hit_scratch) |=> $stable(scratch_q));
endmodule

// File: rtl/nibreg_decoder.sv
module nibreg_decoder
    import nibreg_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2*NIB_W-1:0]   cmd_byte,
    output logic                 reply_valid,
    output logic [2*NIB_W-1:0]   reply_data,
    output logic [2*NIB_W-1:0]   mode_reg,
    output logic [2*NIB_W-1:0]   scratch_reg
);
    localparam int NIBS   = 2;
    localparam int ADDR_W = NIB_W * NIBS;
    localparam int DATA_W = 2 * NIB_W;

    cmd_t              cmd;
    logic [ADDR_W-1:0] addr;
    logic              wr_en, rd_en;
    logic [DATA_W-1:0] wr_data;

    nibreg_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .cmd       (cmd)
    );

    nibreg_ptr #(.NIB_W(NIB_W), .NIBS(NIBS)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en)
    );

    nibreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .reply_valid (reply_valid),
        .reply_data  (reply_data),
        .mode_q      (mode_reg),
        .scratch_q   (scratch_reg)
    );

    // R11
    idle_no_reply_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !reply_valid);
endmodule

// File: tb/nibreg_decoder_tb.sv
module nibreg_decoder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       reply_valid;
    logic [7:0] reply_data, mode_reg, scratch_reg;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    nibreg_decoder u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .reply_valid(reply_valid), .reply_data(reply_data),
        .mode_reg(mode_reg), .scratch_reg(scratch_reg)
    );

    // fields: cmd[20:13], expect reply [12], expected data [11:4], req [3:0]
    localparam int NV = 29;
    localparam logic [20:0] VEC [NV] = '{
        {8'h00, 1'b0, 8'h00, 4'd1},  // R1 addr lo 0
        {8'h10, 1'b0, 8'h00, 4'd1},  // R1 addr hi 0
        {8'h40, 1'b1, 8'hA6, 4'd4},  // R4 id read
        {8'h2F, 1'b0, 8'h00, 4'd2},  // R2 data lo
        {8'h3F, 1'b0, 8'h00, 4'd4},  // R4 write to id
        {8'h40, 1'b1, 8'hA6, 4'd4},  // R4 unchanged
        {8'h0F, 1'b0, 8'h00, 4'd1},  // addr 0x0F
        {8'h25, 1'b0, 8'h00, 4'd2},
        {8'h35, 1'b0, 8'h00, 4'd2},  // R2 write 0x55
        {8'h40, 1'b1, 8'h55, 4'd5},  // R5 back to back
        {8'h2A, 1'b0, 8'h00, 4'd2},
        {8'h3A, 1'b0, 8'h00, 4'd2},
        {8'h40, 1'b1, 8'hAA, 4'd5},  // R5
        {8'h03, 1'b0, 8'h00, 4'd1},  // addr 0x03
        {8'h20, 1'b0, 8'h00, 4'd2},
        {8'h38, 1'b0, 8'h00, 4'd6},  // mode 0x80
        {8'h40, 1'b1, 8'h80, 4'd6},  // R6
        {8'h39, 1'b0, 8'h00, 4'd9},  // R9 reuse low nibble
        {8'h40, 1'b1, 8'h90, 4'd9},
        {8'h5F, 1'b0, 8'h00, 4'd8},  // R8 unknown op
        {8'h40, 1'b1, 8'h90, 4'd8},
        {8'hF0, 1'b0, 8'h00, 4'd8},
        {8'h40, 1'b1, 8'h90, 4'd8},
        {8'h11, 1'b0, 8'h00, 4'd1},  // R1 addr 0x13
        {8'h40, 1'b1, 8'h00, 4'd7},  // R7 unimplemented
        {8'h37, 1'b0, 8'h00, 4'd7},  // R7 write ignored
        {8'h10, 1'b0, 8'h00, 4'd1},  // back to 0x03
        {8'h40, 1'b1, 8'h90, 4'd7},
        {8'h38, 1'b0, 8'h00, 4'd6}   // mode 0x80
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic [7:0] b);
        cmd_valid = v;
        cmd_byte  = b;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 reset reply_valid", {8'h00, reply_valid}, 9'h000);
        chk("R10 reset mode", {1'b0, mode_reg}, 9'h000);
        chk("R10 reset scratch", {1'b0, scratch_reg}, 9'h000);

        for (int i = 0; i < NV; i++) begin
            send(1'b1, VEC[i][20:13]);
            n_chk++;
            if (reply_valid !== VEC[i][12] || (VEC[i][12] && reply_data !== VEC[i][11:4])) begin
                n_bad++;
                $display("FAIL R%0d/R3 vector %0d actual=%b/%h expected=%b/%h",
                         VEC[i][3:0], i, reply_valid, reply_data, VEC[i][12], VEC[i][11:4]);
            end
        end

        // R6 mode output, R5 scratch output
        chk("R6 mode_reg port", {1'b0, mode_reg}, 9'h080);
        chk("R5 scratch_reg port", {1'b0, scratch_reg}, 9'h0AA);

        // R3 single pulse: read then idle
        send(1'b1, 8'h40);
        chk("R3 reply pulse", {reply_data, reply_valid}, {8'h80, 1'b1});
        @(negedge clk);
        chk("R3 reply drops", {8'h00, reply_valid}, 9'h000);

        // R11 ignored while cmd_valid low
        send(1'b0, 8'h40);
        chk("R11 no reply", {8'h00, reply_valid}, 9'h000);
        send(1'b0, 8'h31);
        send(1'b0, 8'h0F);
        chk("R11 mode unchanged", {1'b0, mode_reg}, 9'h080);
        send(1'b1, 8'h40);
        chk("R11 address unchanged", {reply_data, reply_valid}, {8'h80, 1'b1});

        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mode cleared", {1'b0, mode_reg}, 9'h000);
        chk("R10 scratch cleared", {1'b0, scratch_reg}, 9'h000);
        send(1'b1, 8'h40);
        chk("R10 address cleared", {reply_data, reply_valid}, {8'hA6, 1'b1});
        send(1'b1, 8'h0F);
        send(1'b1, 8'h33);
        chk("R10 data nibble cleared", {1'b0, scratch_reg}, 9'h030);
        finish_run();
    end
endmodule